// File: doc/BRIEF.md
# PLL Control and Lock-Event Register

This block is one byte-wide register that sits on a simple processor bus and controls a clock generator's phase-locked loop. It responds to a single fixed address. It holds five things: the PLL power switch, the choice of base clock, a two-bit prescaler code and a two-bit VCO range code, all of which drive the clock logic directly, plus an interrupt enable.

It also records lock events. The lock indication from the analog loop is asynchronous, so the block first synchronizes it. Each time the synchronized value changes, in either direction, a sticky event flag is set. Any bus read of the register clears the flag. An interrupt is raised while both the flag and the enable are set.

The enable and the flag are only in effect while the neighbouring bandwidth control logic reports automatic bandwidth mode. Outside that mode the enable cannot be written, both bits read as zero, and no interrupt is raised.

Top module: `pll_ctl_reg`

## Requirements
- R1: While reset is asserted, and after it is released with no bus access, the register reads 0x20. `pll_on` is 1, `base_sel`, `presc` and `vco_rng` are 0, and `irq` is 0.
- R2: The read layout, from bit 7 down to bit 0, is: interrupt enable, lock-event flag, PLL on, base clock select, prescaler[1:0], VCO range[1:0]. A write at the register address loads bits 5..0 into `pll_on`, `base_sel`, `presc` and `vco_rng`, and these outputs show the new values from the following clock edge onward.
- R3: Only address 0x36 selects the register. A write to any other address changes nothing. A read of any other address returns 0 and does not clear the flag.
- R4: The lock-event flag sets on every transition of `lock_in`, rising or falling. It becomes visible after the third rising clock edge that follows the change: two synchronizer stages, then the flag register.
- R5: A read at the register address clears the flag on the next clock edge. The read data in the cycle of that read shows the flag value from before the clear.
- R6: When a synchronized lock transition and a clearing read fall in the same cycle, the flag ends up set.
- R7: The value written to bit 6 has no effect. The flag cannot be set or cleared by a write.
- R8: While `auto_bw` is 1, `irq` is 1 exactly when the flag and the interrupt enable are both 1.
- R9: While `auto_bw` is 0, a write leaves the stored interrupt enable unchanged, bits 7 and 6 read as 0, and `irq` is 0.
- R10: `bus_rdata` is 0 in any cycle without a read strobe at the register address. During a read it is combinational and shows the register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 unless the register is being read |
| lock_in | input | 1 | Asynchronous lock indication from the PLL |
| auto_bw | input | 1 | Automatic bandwidth mode from the bandwidth control logic |
| irq | output | 1 | Lock-change interrupt request |
| pll_on | output | 1 | PLL power switch |
| base_sel | output | 1 | Base clock select |
| presc | output | 2 | Prescaler code |
| vco_rng | output | 2 | VCO power-of-two range code |

## Verification
Directed sequences cover four patterns:
- A lock rise followed later by a lock fall. This shows that both edges set the flag and that the flag appears with the expected three-edge latency.
- A clearing read placed exactly in the cycle of a synchronized transition. This separates set-wins from clear-wins.
- Accesses at other addresses. These separate full address decode from partial decode.
- Writes and reads with automatic mode off. These separate masking at read time from loss of the stored enable.

A seeded random stream then mixes reads, writes, read-with-write cycles, lock toggles and mode changes. Every cycle is compared against a cycle-accurate bench model, which exposes ordering errors between the synchronizer, the flag and the read path.

// File: rtl/pllc_pkg.sv
package pllc_pkg;
  localparam int REG_W   = 8;
  localparam int PRE_W   = 2;
  localparam int VCO_W   = 2;
  // bit positions decoded by software and the clock logic
  localparam int B_IE    = 7;
  localparam int B_FLAG  = 6;
  localparam int B_ON    = 5;
  localparam int CTL_W   = B_ON + 1;

  typedef struct packed {
    logic             on;
    logic             bcs;
    logic [PRE_W-1:0] presc;
    logic [VCO_W-1:0] vco;
  } ctl_t;

  localparam ctl_t CTL_RST = '{on: 1'b1, bcs: 1'b0, presc: '0, vco: '0};
endpackage

// File: rtl/pllc_lock_sync.sv
module pllc_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_async,
  output logic toggle
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      logic d;
      if (i == 0) begin : g_first
        assign d = lock_async;
      end else begin : g_next
        assign d = sync_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= d;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign toggle = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/pllc_flag.sv
module pllc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag_q
);
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_evt) flag_d = 1'b0;
    if (set_evt) flag_d = 1'b1;   // a new event outranks the clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/pllc_ctl_fields.sv
module pllc_ctl_fields
  import pllc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic             auto_bw,
  input  logic [REG_W-1:0] wdata,
  output ctl_t             ctl_q,
  output logic             ie_q
);
  ctl_t ctl_d;
  logic ie_d, ctl_ce, ie_ce;
  logic unused_flag_bit;

  assign unused_flag_bit = wdata[B_FLAG];

  always_comb begin
    ctl_ce = wr_hit;
    ie_ce  = wr_hit & auto_bw;
    ctl_d  = ctl_t'(wdata[CTL_W-1:0]);
    ie_d   = wdata[B_IE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RST;
      ie_q  <= 1'b0;
    end else begin
      if (ctl_ce) ctl_q <= ctl_d;
      if (ie_ce)  ie_q  <= ie_d;
    end
  end
endmodule

// File: rtl/pll_ctl_reg.sv
module pll_ctl_reg
  import pllc_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h36,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              lock_in,
  input  logic              auto_bw,
  output logic              irq,
  output logic              pll_on,
  output logic              base_sel,
  output logic [PRE_W-1:0]  presc,
  output logic [VCO_W-1:0]  vco_rng
);
  logic sel, rd_hit, wr_hit;
  logic lock_tog, flag_q, en_q;
  ctl_t ctl_q;

  assign sel    = (bus_addr == REG_ADDR);
  assign rd_hit = sel & bus_rd;
  assign wr_hit = sel & bus_wr;

  pllc_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .lock_async(lock_in), .toggle(lock_tog)
  );

  pllc_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_evt(lock_tog), .clr_evt(rd_hit), .flag_q(flag_q)
  );

  pllc_ctl_fields u_fields (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .auto_bw(auto_bw),
    .wdata(bus_wdata), .ctl_q(ctl_q), .ie_q(en_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      bus_rdata[B_IE]      = en_q & auto_bw;
      bus_rdata[B_FLAG]    = flag_q & auto_bw;
      bus_rdata[CTL_W-1:0] = ctl_q;
    end
  end

  assign irq      = flag_q & en_q & auto_bw;
  assign pll_on   = ctl_q.on;
  assign base_sel = ctl_q.bcs;
  assign presc    = ctl_q.presc;
  assign vco_rng  = ctl_q.vco;
endmodule

// File: rtl/pllc_chk.sv
module pllc_chk #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h36
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [7:0]        bus_rdata,
  input logic              auto_bw,
  input logic              irq,
  input logic              pll_on,
  input logic              base_sel,
  input logic [1:0]        presc,
  input logic [1:0]        vco_rng,
  input logic              flag_q,
  input logic              en_q,
  input logic              lock_tog
);
  // R4
  flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_tog |=> flag_q);
  // R5
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == REG_ADDR && !lock_tog) |=> !flag_q);
  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (auto_bw && en_q && flag_q));
  // R9
  en_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_bw |=> $stable(en_q));
  // R3
  foreign_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != REG_ADDR) |=> $stable({pll_on, base_sel, presc, vco_rng}));
  // R10
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == 8'h00));
endmodule

bind pll_ctl_reg pllc_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .auto_bw(auto_bw), .irq(irq), .pll_on(pll_on),
  .base_sel(base_sel), .presc(presc), .vco_rng(vco_rng), .flag_q(flag_q),
  .en_q(en_q), .lock_tog(lock_tog)
);

// File: tb/test_pll_ctl_reg.sv
module test_pll_ctl_reg;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_REG = 8'h36;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr;
  logic       bus_rd, bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       lock_in, auto_bw;
  logic       irq, pll_on, base_sel;
  logic [1:0] presc, vco_rng;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_ctl_reg i_pll_ctl_reg (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_in(lock_in), .auto_bw(auto_bw),
    .irq(irq), .pll_on(pll_on), .base_sel(base_sel), .presc(presc), .vco_rng(vco_rng)
  );

  // bench model of the requirements
  logic m_s1, m_s2, m_prev, m_flag, m_ie;
  logic [5:0] m_ctl;

  function automatic logic [7:0] exp_rdata();
    if (bus_rd && bus_addr == A_REG)
      return {m_ie & auto_bw, m_flag & auto_bw, m_ctl};
    return 8'h00;
  endfunction

  function automatic logic exp_irq();
    return m_flag & m_ie & auto_bw;
  endfunction

  task automatic model_reset();
    m_s1 = 0; m_s2 = 0; m_prev = 0; m_flag = 0; m_ie = 0; m_ctl = 6'h20;
  endtask

  task automatic model_edge();
    logic tog;
    logic hit;
    hit = (bus_addr == A_REG);
    tog = m_s2 ^ m_prev;
    m_prev = m_s2; m_s2 = m_s1; m_s1 = lock_in;
    if (hit && bus_rd) m_flag = 0;
    if (tog) m_flag = 1;
    if (hit && bus_wr) begin
      m_ctl = bus_wdata[5:0];
      if (auto_bw) m_ie = bus_wdata[7];
    end
  endtask

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", tag, what, act, exp);
    end
  endtask

  task automatic cycle(string tag, logic [7:0] a, logic rd, logic wr, logic [7:0] wd,
                       logic lk, logic ab);
    @(negedge clk);
    bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd; lock_in = lk; auto_bw = ab;
    #1;
    chk(tag, "rdata", bus_rdata, exp_rdata());
    chk(tag, "irq", {7'd0, irq}, {7'd0, exp_irq()});
    chk(tag, "ctl", {2'd0, pll_on, base_sel, presc, vco_rng}, {2'd0, m_ctl});
    @(posedge clk);
    model_edge();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic lk, ab;
    void'($urandom(32'h5EED_0C1A));
    rst_n = 0; bus_addr = 0; bus_rd = 0; bus_wr = 0; bus_wdata = 0; lock_in = 0; auto_bw = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    chk("R1", "ctl_in_reset", {2'd0, pll_on, base_sel, presc, vco_rng}, 8'h20);
    @(negedge clk); rst_n = 1;
    // R1 read after reset, auto on so masked bits are visible
    cycle("R1", A_REG, 1, 0, 8'h00, 0, 1);
    // R2 R7 write all ones, flag bit ignored
    cycle("R2", A_REG, 0, 1, 8'hFF, 0, 1);
    cycle("R7", A_REG, 1, 0, 8'h00, 0, 1);
    cycle("R2", A_REG, 0, 1, 8'h9A, 0, 1);
    cycle("R2", A_REG, 1, 0, 8'h00, 0, 1);
    // R4 rising lock
    cycle("R4", 8'h00, 0, 0, 8'h00, 1, 1);
    repeat (3) cycle("R4", 8'h00, 0, 0, 8'h00, 1, 1);
    // R8 irq visible, R5 read clears
    cycle("R5", A_REG, 1, 0, 8'h00, 1, 1);
    cycle("R5", A_REG, 1, 0, 8'h00, 1, 1);
    // R4 falling lock
    cycle("R4", 8'h00, 0, 0, 8'h00, 0, 1);
    repeat (3) cycle("R8", 8'h00, 0, 0, 8'h00, 0, 1);
    cycle("R5", A_REG, 1, 0, 8'h00, 0, 1);
    // R6 read coincides with synchronized toggle
    cycle("R6", 8'h00, 0, 0, 8'h00, 1, 1);
    cycle("R6", 8'h00, 0, 0, 8'h00, 1, 1);
    cycle("R6", A_REG, 1, 0, 8'h00, 1, 1);
    cycle("R6", A_REG, 1, 0, 8'h00, 1, 1);
    // R3 other address: no write, no clear, zero data
    cycle("R3", 8'h00, 0, 0, 8'h00, 0, 1);
    repeat (3) cycle("R3", 8'h00, 0, 0, 8'h00, 0, 1);
    cycle("R3", 8'h37, 1, 1, 8'h00, 0, 1);
    cycle("R3", 8'hB6, 1, 1, 8'h00, 0, 1);
    cycle("R3", A_REG, 1, 0, 8'h00, 0, 1);
    // R9 auto off: enable write blocked, masked read, no irq
    cycle("R9", 8'h00, 0, 0, 8'h00, 1, 0);
    repeat (3) cycle("R9", 8'h00, 0, 0, 8'h00, 1, 0);
    cycle("R9", A_REG, 0, 1, 8'h25, 1, 0);
    cycle("R9", A_REG, 0, 0, 8'h00, 1, 1);
    cycle("R9", A_REG, 1, 0, 8'h00, 1, 1);
    // R10 random mix
    lk = 1; ab = 1;
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] a;
      a = ($urandom_range(0, 1) == 0) ? A_REG : 8'($urandom);
      if ($urandom_range(0, 5) == 0) lk = ~lk;
      if ($urandom_range(0, 19) == 0) ab = ~ab;
      cycle("R10", a, ($urandom_range(0, 2) == 0), ($urandom_range(0, 2) == 0),
            8'($urandom), lk, ab);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule